// File: doc/BRIEF.md
# Counter-Event Interrupt Flag Register

This block holds the sticky interrupt flags of a scan and sensing peripheral. Hardware sources set the flags. These sources are two counters (one counting up, one counting down), a threshold event from a third counter, a state machine's transition strobe with two output bits, a selectable analog front-end output and three generic event strobes. Software reads the flags and clears them through a simple 16-bit register port. A flag is cleared by writing 0 to its bit.

For each of the two counters, a 2-bit select field in the same register chooses which count condition raises that counter's flag. The choices are every count, every count that lands on a multiple of 4, every count that lands on a multiple of 256, or only the terminal wrap. For the up-counter the wrap is all-ones to zero. For the down-counter it is one to zero. A single interrupt request output combines all set flags, each gated by its own enable input.

Top module: `scan_irq_flags`

## Requirements
- R1: After synchronous reset, `rd_data` reads 0x0000 and `irq` is 0.
- R2: Bits 15, 12 and 9 of `rd_data` always read 0, whatever was written.
- R3: A write stores `wr_data[14:13]` as the down-counter select and `wr_data[11:10]` as the up-counter select. Both read back at the same positions. Encoding: 00 every count, 01 value mod 4 = 0, 10 value mod 256 = 0, 11 terminal wrap. A newly written select takes effect from the next cycle.
- R4: Flags are `rd_data[8:0]` and they are sticky. During a write, a flag whose `wr_data` bit is 0 is cleared. A flag whose `wr_data` bit is 1 keeps its value. Without a write, flags are never cleared.
- R5: When a hardware set and a clear by write hit the same flag in the same cycle, the flag ends up set.
- R6: Flag 4 is set only in cycles where `dn_stb` is 1. The condition is chosen by the down select and tested on `dn_val`, the value after the update. Mode 11 needs `dn_val` = 0 while the value sampled one clock earlier was 0x0001.
- R7: Flag 7 follows the same rule with `up_stb`, `up_val` and the up select. Mode 11 needs `up_val` = 0 while the value sampled one clock earlier was 0xFFFF.
- R8: In a cycle with `fsm_stb` = 1, flag 6 is set if `fsm_q7` is 1 and flag 5 is set if `fsm_q6` is 1. Without the strobe, neither flag is set.
- R9: Flag 8 is set when `afe_out[afe_sel]` is 1. The other `afe_out` lines have no effect.
- R10: Flag 3 is set by `thr_evt`. Flags 2:0 are set by `gen_evt[2:0]`, bit for bit.
- R11: `irq` equals the OR of `rd_data[8:0] & irq_en` and follows the flags in the same cycle.
- R12: Flags and selects change one clock after the event or write that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Register contents (combinational read) |
| up_stb | input | 1 | Up-counter count strobe |
| up_val | input | 16 | Up-counter value after update |
| dn_stb | input | 1 | Down-counter count strobe |
| dn_val | input | 16 | Down-counter value after update |
| thr_evt | input | 1 | Threshold event from third counter |
| fsm_stb | input | 1 | State-transition strobe |
| fsm_q7 | input | 1 | High output bit of the entered state |
| fsm_q6 | input | 1 | Second output bit of the entered state |
| afe_out | input | 4 | Front-end output events |
| afe_sel | input | 2 | Selects the front-end output that sets flag 8 |
| gen_evt | input | 3 | Generic event strobes for flags 2:0 |
| irq_en | input | 9 | Per-flag interrupt enables |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land on the same flag bit in one cycle: a hardware set from an event source and a software clear through the write port. The random phase drives event strobes and writes with random data together on many cycles. The directed phase writes 0 to a flag while its generic event is active. In every such collision, a bench model in which set overrides clear predicts the result, and the bench compares it with the register read back one clock later. The same comparison covers a write that changes a select field while that counter strobes: the old select must still decide that cycle.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;

    localparam int REG_W       = 16;
    localparam int FLAG_N      = 9;
    localparam int GEN_N       = 3;

    // flag positions (decoded by software, so fixed)
    localparam int F_THR       = 3;
    localparam int F_DN        = 4;
    localparam int F_Q6        = 5;
    localparam int F_Q7        = 6;
    localparam int F_UP        = 7;
    localparam int F_AFE       = 8;

    // select field positions
    localparam int UP_SEL_LSB  = 10;
    localparam int DN_SEL_LSB  = 13;

    typedef enum logic [1:0] {
        CNT_EACH   = 2'b00,
        CNT_MOD4   = 2'b01,
        CNT_MOD256 = 2'b10,
        CNT_WRAP   = 2'b11
    } cnt_sel_e;

    typedef struct packed {
        cnt_sel_e dn_sel;
        cnt_sel_e up_sel;
    } sel_cfg_t;

    typedef struct packed {
        logic             fsm_stb;
        logic             q7;
        logic             q6;
    } fsm_evt_t;

    // assemble the readable image; reserved positions stay zero
    function automatic logic [REG_W-1:0] pack_reg(sel_cfg_t cfg,
                                                  logic [FLAG_N-1:0] flags);
        logic [REG_W-1:0] r;
        r = '0;
        r[FLAG_N-1:0]          = flags;
        r[UP_SEL_LSB +: 2]     = cfg.up_sel;
        r[DN_SEL_LSB +: 2]     = cfg.dn_sel;
        return r;
    endfunction

    // per-flag keep mask: a written 0 clears, everything else keeps
    function automatic logic [FLAG_N-1:0] keep_mask(logic wr_en,
                                                    logic [REG_W-1:0] wdata);
        return wr_en ? wdata[FLAG_N-1:0] : {FLAG_N{1'b1}};
    endfunction

endpackage

// File: rtl/scan_irq_cnt_trig.sv
module scan_irq_cnt_trig
    import scan_irq_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter bit WRAP_UP = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_sel_e         sel,
    input  logic             stb,
    input  logic [CNT_W-1:0] val,
    output logic             hit
);

    localparam int LOW_W = (CNT_W < 8) ? CNT_W : 8;
    localparam int Q_W   = (CNT_W < 2) ? CNT_W : 2;

    logic [CNT_W-1:0] prev_val;
    logic             wrap_seen;
    logic             mod4_zero;
    logic             mod256_zero;
    logic             now_zero;

    always_ff @(posedge clk) begin
        if (rst) prev_val <= '0;
        else     prev_val <= val;
    end

    assign now_zero    = (val == '0);
    assign mod4_zero   = (val[Q_W-1:0] == '0);
    assign mod256_zero = (val[LOW_W-1:0] == '0);

    generate
        if (WRAP_UP) begin : g_up_wrap
            assign wrap_seen = now_zero && (prev_val == {CNT_W{1'b1}});
        end else begin : g_dn_wrap
            assign wrap_seen = now_zero &&
                               (prev_val == {{(CNT_W-1){1'b0}}, 1'b1});
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        if (stb) begin
            unique case (sel)
                CNT_EACH:   hit = 1'b1;
                CNT_MOD4:   hit = mod4_zero;
                CNT_MOD256: hit = mod256_zero;
                CNT_WRAP:   hit = wrap_seen;
                default:    hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/scan_irq_sel_cfg.sv
module scan_irq_sel_cfg
    import scan_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output sel_cfg_t         cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.up_sel <= CNT_EACH;
            cfg.dn_sel <= CNT_EACH;
        end else if (wr_en) begin
            cfg.up_sel <= cnt_sel_e'(wr_data[UP_SEL_LSB +: 2]);
            cfg.dn_sel <= cnt_sel_e'(wr_data[DN_SEL_LSB +: 2]);
        end
    end

endmodule

// File: rtl/scan_irq_flag_bank.sv
module scan_irq_flag_bank #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] keep,
    output logic [N-1:0] flags
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_cell
            always_ff @(posedge clk) begin
                if (rst) flags[i] <= 1'b0;
                else     flags[i] <= set_vec[i] | (flags[i] & keep[i]);
            end
        end
    endgenerate

endmodule

// File: rtl/scan_irq_flags.sv
module scan_irq_flags
    import scan_irq_pkg::*;
#(
    parameter int UP_W  = 16,
    parameter int DN_W  = 16,
    parameter int AFE_N = 4,
    localparam int AFE_SW = (AFE_N > 1) ? $clog2(AFE_N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    input  logic              up_stb,
    input  logic [UP_W-1:0]   up_val,
    input  logic              dn_stb,
    input  logic [DN_W-1:0]   dn_val,
    input  logic              thr_evt,
    input  logic              fsm_stb,
    input  logic              fsm_q7,
    input  logic              fsm_q6,
    input  logic [AFE_N-1:0]  afe_out,
    input  logic [AFE_SW-1:0] afe_sel,
    input  logic [2:0]        gen_evt,
    input  logic [8:0]        irq_en,
    output logic              irq
);

    sel_cfg_t          cfg;
    fsm_evt_t          fsm_ev;
    logic              up_hit;
    logic              dn_hit;
    logic              afe_hit;
    logic [FLAG_N-1:0] set_vec;
    logic [FLAG_N-1:0] flags;

    scan_irq_sel_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    scan_irq_cnt_trig #(.CNT_W(UP_W), .WRAP_UP(1'b1)) u_up_trig (
        .clk (clk),
        .rst (rst),
        .sel (cfg.up_sel),
        .stb (up_stb),
        .val (up_val),
        .hit (up_hit)
    );

    scan_irq_cnt_trig #(.CNT_W(DN_W), .WRAP_UP(1'b0)) u_dn_trig (
        .clk (clk),
        .rst (rst),
        .sel (cfg.dn_sel),
        .stb (dn_stb),
        .val (dn_val),
        .hit (dn_hit)
    );

    assign fsm_ev  = '{fsm_stb: fsm_stb, q7: fsm_q7, q6: fsm_q6};
    assign afe_hit = (int'(afe_sel) < AFE_N) ? afe_out[afe_sel] : 1'b0;

    always_comb begin
        set_vec              = '0;
        set_vec[GEN_N-1:0]   = gen_evt;
        set_vec[F_THR]       = thr_evt;
        set_vec[F_DN]        = dn_hit;
        set_vec[F_Q6]        = fsm_ev.fsm_stb & fsm_ev.q6;
        set_vec[F_Q7]        = fsm_ev.fsm_stb & fsm_ev.q7;
        set_vec[F_UP]        = up_hit;
        set_vec[F_AFE]       = afe_hit;
    end

    scan_irq_flag_bank #(.N(FLAG_N)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .keep    (keep_mask(wr_en, wr_data)),
        .flags   (flags)
    );

    assign rd_data = pack_reg(cfg, flags);
    assign irq     = |(flags & irq_en);

endmodule

// File: rtl/scan_irq_flags_chk.sv
module scan_irq_flags_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data,
    input logic        up_stb,
    input logic [15:0] up_val,
    input logic        dn_stb,
    input logic        fsm_stb,
    input logic        fsm_q7,
    input logic [2:0]  gen_evt,
    input logic        irq
);

    p_resv_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_data[15] == 1'b0) && (rd_data[12] == 1'b0) && (rd_data[9] == 1'b0));

    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((rd_data[8:0] & $past(rd_data[8:0])) == $past(rd_data[8:0])));

    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[0] && !gen_evt[0]) |=> !rd_data[0]);

    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        gen_evt[1] |=> rd_data[1]);

    p_dn_each_r6: assert property (@(posedge clk) disable iff (rst)
        (dn_stb && rd_data[14:13] == 2'b00) |=> rd_data[4]);

    p_up_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (up_stb && rd_data[11:10] == 2'b11 && up_val == 16'h0000 &&
         $past(up_val) == 16'hFFFF) |=> rd_data[7]);

    p_fsm_q7_r8: assert property (@(posedge clk) disable iff (rst)
        (fsm_stb && fsm_q7) |=> rd_data[6]);

    p_irq_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_data[8:0] == 9'd0) |-> !irq);

endmodule

bind scan_irq_flags scan_irq_flags_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .up_stb  (up_stb),
    .up_val  (up_val),
    .dn_stb  (dn_stb),
    .fsm_stb (fsm_stb),
    .fsm_q7  (fsm_q7),
    .gen_evt (gen_evt),
    .irq     (irq)
);

// File: tb/scan_irq_flags_bench.sv
module scan_irq_flags_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        up_stb = 1'b0;
    logic [15:0] up_val = '0;
    logic        dn_stb = 1'b0;
    logic [15:0] dn_val = '0;
    logic        thr_evt = 1'b0;
    logic        fsm_stb = 1'b0;
    logic        fsm_q7 = 1'b0;
    logic        fsm_q6 = 1'b0;
    logic [3:0]  afe_out = '0;
    logic [1:0]  afe_sel = '0;
    logic [2:0]  gen_evt = '0;
    logic [8:0]  irq_en = '0;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model state
    logic [8:0]  m_flags = '0;
    logic [1:0]  m_up = '0;
    logic [1:0]  m_dn = '0;
    logic [15:0] p_up = '0;
    logic [15:0] p_dn = '0;

    always #4 clk = ~clk;

    scan_irq_flags u_scan_irq_flags (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wr_data),
        .rd_data (rd_data), .up_stb (up_stb), .up_val (up_val),
        .dn_stb (dn_stb), .dn_val (dn_val), .thr_evt (thr_evt),
        .fsm_stb (fsm_stb), .fsm_q7 (fsm_q7), .fsm_q6 (fsm_q6),
        .afe_out (afe_out), .afe_sel (afe_sel), .gen_evt (gen_evt),
        .irq_en (irq_en), .irq (irq)
    );

    function automatic logic cnt_fires(input logic [1:0] md, input logic stb,
                                       input logic [15:0] v, input logic [15:0] pv,
                                       input logic is_up);
        if (!stb) return 1'b0;
        case (md)
            2'd0:    return 1'b1;
            2'd1:    return (v % 4) == 0;
            2'd2:    return (v % 256) == 0;
            default: return (v == 16'h0000) && (is_up ? (pv == 16'hFFFF) : (pv == 16'h0001));
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2 reserved", {13'd0, rd_data[15], rd_data[12], rd_data[9]}, 16'h0000);
        chk("R3 selects", {12'd0, rd_data[14:13], rd_data[11:10]}, {12'd0, m_dn, m_up});
        chk("R6 flag4", {15'd0, rd_data[4]}, {15'd0, m_flags[4]});
        chk("R7 flag7", {15'd0, rd_data[7]}, {15'd0, m_flags[7]});
        chk("R8 flags6:5", {14'd0, rd_data[6:5]}, {14'd0, m_flags[6:5]});
        chk("R9 flag8", {15'd0, rd_data[8]}, {15'd0, m_flags[8]});
        chk("R10 flags3:0", {12'd0, rd_data[3:0]}, {12'd0, m_flags[3:0]});
        chk("R11 irq", {15'd0, irq}, {15'd0, |(m_flags & irq_en)});
    endtask

    // one clock: predict from inputs now driven, then compare at the next falling edge (R12)
    task automatic step();
        logic [8:0] hw;
        hw = '0;
        hw[2:0] = gen_evt;
        hw[3]   = thr_evt;
        hw[4]   = cnt_fires(m_dn, dn_stb, dn_val, p_dn, 1'b0);
        hw[5]   = fsm_stb & fsm_q6;
        hw[6]   = fsm_stb & fsm_q7;
        hw[7]   = cnt_fires(m_up, up_stb, up_val, p_up, 1'b1);
        hw[8]   = afe_out[afe_sel];
        @(posedge clk);
        if (wr_en) begin
            m_flags = hw | (m_flags & wr_data[8:0]);
            m_up    = wr_data[11:10];
            m_dn    = wr_data[14:13];
        end else begin
            m_flags = m_flags | hw;
        end
        p_up = up_val;
        p_dn = dn_val;
        @(negedge clk);
        check_all();
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_data = '0; up_stb = 0; dn_stb = 0; thr_evt = 0;
        fsm_stb = 0; fsm_q7 = 0; fsm_q6 = 0; afe_out = '0; gen_evt = '0;
    endtask

    function automatic logic [15:0] pick_val();
        case ($urandom_range(0, 5))
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'hFFFF;
            3: return 16'($urandom_range(0, 255)) << 8;
            4: return 16'($urandom_range(0, 15)) << 2;
            default: return 16'($urandom());
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        irq_en = 9'h1FF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset image
        chk("R1 rd_data", rd_data, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);

        // R2 and R3: write all ones, reserved stays zero, selects stored
        wr_en = 1; wr_data = 16'hFFFF;
        step();
        chk("R2 after all-ones write", rd_data & 16'h9200, 16'h0000);
        chk("R3 selects all ones", rd_data & 16'h6C00, 16'h6C00);

        // R5: set and clear on flag 0 in the same cycle
        wr_en = 1; wr_data = 16'h0000; gen_evt = 3'b001;
        step();
        chk("R5 set beats clear", {15'd0, rd_data[0]}, 16'h0001);

        // R4: write 1 keeps, write 0 clears
        idle_inputs();
        wr_en = 1; wr_data = 16'h0001;
        step();
        chk("R4 write one keeps", {15'd0, rd_data[0]}, 16'h0001);
        wr_data = 16'h0000;
        step();
        chk("R4 write zero clears", {15'd0, rd_data[0]}, 16'h0000);

        // R7 wrap mode on the up-counter
        wr_data = 16'h0C00;
        step();
        idle_inputs();
        up_val = 16'h0005;
        step();
        up_stb = 1; up_val = 16'h0000;
        step();
        chk("R7 zero without wrap", {15'd0, rd_data[7]}, 16'h0000);
        up_stb = 0; up_val = 16'hFFFF;
        step();
        up_stb = 1; up_val = 16'h0000;
        step();
        chk("R7 wrap FFFF to 0", {15'd0, rd_data[7]}, 16'h0001);

        // R6 wrap mode on the down-counter
        idle_inputs();
        wr_en = 1; wr_data = 16'h6000;
        step();
        idle_inputs();
        dn_val = 16'h0001;
        step();
        dn_stb = 1; dn_val = 16'h0000;
        step();
        chk("R6 wrap 1 to 0", {15'd0, rd_data[4]}, 16'h0001);

        // R9: non-selected front-end line has no effect
        idle_inputs();
        wr_en = 1; wr_data = 16'h0000;
        step();
        idle_inputs();
        afe_sel = 2'd2; afe_out = 4'b1011;
        step();
        chk("R9 unselected lines", {15'd0, rd_data[8]}, 16'h0000);
        afe_out = 4'b0100;
        step();
        chk("R9 selected line", {15'd0, rd_data[8]}, 16'h0001);

        // R8: q bits without strobe do nothing
        idle_inputs();
        fsm_q7 = 1; fsm_q6 = 1;
        step();
        chk("R8 no strobe", {14'd0, rd_data[6:5]}, 16'h0000);

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            wr_en   = ($urandom_range(0, 7) == 0);
            wr_data = 16'($urandom());
            up_stb  = $urandom_range(0, 1) == 1;
            up_val  = pick_val();
            dn_stb  = $urandom_range(0, 1) == 1;
            dn_val  = pick_val();
            thr_evt = ($urandom_range(0, 5) == 0);
            fsm_stb = ($urandom_range(0, 3) == 0);
            fsm_q7  = $urandom_range(0, 1) == 1;
            fsm_q6  = $urandom_range(0, 1) == 1;
            afe_out = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'd0;
            afe_sel = 2'($urandom());
            gen_evt = ($urandom_range(0, 3) == 0) ? 3'($urandom()) : 3'd0;
            irq_en  = 9'($urandom());
            step();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule